// File: doc/BRIEF.md
# Falling Pulse Capture Latches

This block watches two asynchronous input pins for low-going pulses and remembers each qualifying pulse in a sticky latch, one latch per pin. A pulse qualifies only if the pin falls from high to low and then stays low for at least a set number of instruction cycles. The instruction cycles are marked by a one-clock strobe. Shorter glitches are discarded.

When the processor executes the input-latches instruction, it asserts a read strobe and takes a 4-bit word from the block. Bit 3 carries the latch of pin A. Bit 0 carries the latch of pin B. Bit 2 carries either the level of a clock pin or a constant 1, chosen by a configuration bit. Bit 1 carries a copy of accumulator bit 0. The read also clears both latches, so later pulses can be captured again.

Top module: `pulse_latch_port`

## Requirements
- R1: Each pin passes through a two-flop synchronizer and one edge register. The latch for that pin sets when the synchronized level falls from 1 to 0 and then stays 0 at two instruction-cycle strobes. These strobes are counted only from the clock edge after the fall is detected. For a pin driven low just before clock edge k and driven high again just before edge k+W, only strobes at edges k+3 through k+W+1 count.
- R2: Bit 3 of `result_o` shows the latch of `pin_a_i`, and bit 0 shows the latch of `pin_b_i`. A pulse on one pin never sets the other pin's bit.
- R3: The result word is combinational. When `rd_i` is high at a clock edge, both latches clear at that edge. During the read cycle the word still shows the values from before the clear.
- R4: `result_o[2]` equals `ckpin_i` when `ckpin_gp_i` is 1, and is 1 when `ckpin_gp_i` is 0.
- R5: `result_o[1]` equals `acc0_i`.
- R6: An active-low reset clears both latches while it is held.
- R7: If a pulse qualifies at the same clock edge that a read clears the latches, that latch ends up set.
- R8: A low period that ends before its second counted strobe does not set the latch. The strobe count starts again from zero at the next falling edge. A single low period sets the latch at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a_i | input | 1 | Asynchronous pin feeding result bit 3 |
| pin_b_i | input | 1 | Asynchronous pin feeding result bit 0 |
| cyc_stb_i | input | 1 | One-clock strobe, once per instruction cycle |
| rd_i | input | 1 | Read strobe; clears the latches at the clock edge |
| acc0_i | input | 1 | Current accumulator bit 0 |
| ckpin_i | input | 1 | Level of the clock pin |
| ckpin_gp_i | input | 1 | 1 when the clock pin is configured as a general-purpose input |
| result_o | output | 4 | Word returned to the accumulator |

## Verification
A pulse can qualify at the same clock edge that a read clears the latches. The bench provokes this on purpose: from the instant the pin is driven low, it works out the edge of the second counted strobe and asserts `rd_i` for exactly that edge. The collision is judged correct if the word still shows the latch set on the next cycle, and a later read then clears it. The pulse-width sweep covers every combination of width and strobe period. This shows that the strobe in the detection cycle is never counted.

// File: rtl/pulse_latch_pkg.sv
package pulse_latch_pkg;

  // Bit 2 of the word: pin level in general-purpose mode, else forced high
  function automatic logic ck_field(input logic gp, input logic lvl);
    return gp ? lvl : 1'b1;
  endfunction

  // Assemble the returned word from its four sources
  function automatic logic [3:0] pack_word(input logic lat_a, input logic ck,
                                           input logic acc0, input logic lat_b);
    return {lat_a, ck, acc0, lat_b};
  endfunction

endpackage

// File: rtl/pl_sync.sv
module pl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh;

  // Reset to the idle-high level so no false fall is seen after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], d_i};
  end

  assign q_o = sh[STAGES-1];
endmodule

// File: rtl/pl_width_qual.sv
module pl_width_qual #(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic stb_i,
  output logic fall_o,
  output logic hit_o
);
  localparam int CNT_W = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_LOW - 1);

  logic             prev;
  logic             armed;
  logic [CNT_W-1:0] cnt;

  assign fall_o = prev & ~lvl_i;
  assign hit_o  = armed & ~lvl_i & stb_i & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= 1'b1;
      armed <= 1'b0;
      cnt   <= '0;
    end else begin
      prev <= lvl_i;
      if (fall_o) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed) begin
        if (lvl_i)       armed <= 1'b0;
        else if (hit_o)  armed <= 1'b0;
        else if (stb_i)  cnt   <= cnt + 1'b1;
      end
    end
  end

  // R1
  hit_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> stb_i && !lvl_i);

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R8
  one_hit_per_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !hit_o);
endmodule

// File: rtl/pulse_latch_port.sv
module pulse_latch_port #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_a_i,
  input  logic       pin_b_i,
  input  logic       cyc_stb_i,
  input  logic       rd_i,
  input  logic       acc0_i,
  input  logic       ckpin_i,
  input  logic       ckpin_gp_i,
  output logic [3:0] result_o
);
  import pulse_latch_pkg::*;

  localparam int NPIN = 2;

  logic [NPIN-1:0] pin_vec;
  logic [NPIN-1:0] lvl;
  logic [NPIN-1:0] fall;
  logic [NPIN-1:0] hit;
  logic [NPIN-1:0] lat;

  // index 1 feeds bit 3, index 0 feeds bit 0
  assign pin_vec = {pin_a_i, pin_b_i};

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_vec[i]), .q_o(lvl[i]));

    pl_width_qual #(.MIN_LOW(MIN_LOW)) u_qual (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl[i]), .stb_i(cyc_stb_i),
      .fall_o(fall[i]), .hit_o(hit[i]));

    // set wins over the read clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat[i] <= 1'b0;
      else if (hit[i]) lat[i] <= 1'b1;
      else if (rd_i)   lat[i] <= 1'b0;
    end

    // R1
    set_from_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lat[i]) |-> $past(hit[i]));

    // R3
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i && !hit[i] |=> !lat[i]);

    // R7
    set_beats_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i && hit[i] |=> lat[i]);
  end

  assign result_o = pack_word(lat[1], ck_field(ckpin_gp_i, ckpin_i), acc0_i, lat[0]);

  // R4
  ck_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ckpin_gp_i |-> result_o[2]);

  // R5
  acc_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_o[1] == acc0_i);
endmodule

// File: tb/pulse_latch_port_tb.sv
module pulse_latch_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_a = 1'b1, pin_b = 1'b1;
  logic cyc_stb = 1'b0, rd = 1'b0, acc0 = 1'b0, ckpin = 1'b0, ckgp = 1'b0;
  logic [3:0] res;

  int ncyc = 0;
  int per = 1;
  int nchk = 0;
  int nbad = 0;

  pulse_latch_port u_dut (
    .clk(clk), .rst_n(rst_n), .pin_a_i(pin_a), .pin_b_i(pin_b),
    .cyc_stb_i(cyc_stb), .rd_i(rd), .acc0_i(acc0), .ckpin_i(ckpin),
    .ckpin_gp_i(ckgp), .result_o(res));

  always #5 clk = ~clk;
  always @(posedge clk) ncyc <= ncyc + 1;
  // strobe for edge e is high when e is a multiple of per
  always @(negedge clk) cyc_stb <= ((ncyc + 1) % per == 0);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, logic got, logic exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %b expected %b at cycle %0d", req, got, exp, ncyc);
    end
  endtask

  function automatic int counted(int k, int w, int p);
    int n = 0;
    for (int e = k + 3; e <= k + w + 1; e++) if (e % p == 0) n++;
    return n;
  endfunction

  task automatic drive_pin(int which, logic v);
    if (which == 1) pin_a = v; else pin_b = v;
  endtask

  function automatic logic bit_of(int which);
    return (which == 1) ? res[3] : res[0];
  endfunction

  task automatic trial(int which, int w, int p);
    int k;
    logic exp;
    per = p;
    repeat (3) tick();
    drive_pin(which, 1'b0);
    k = ncyc + 1;
    repeat (w) tick();
    drive_pin(which, 1'b1);
    repeat (4) tick();
    exp = (counted(k, w, p) >= 2);
    check(exp ? "R1" : "R8", bit_of(which), exp);
    check("R2", bit_of(1 - which), 1'b0);
    rd = 1'b1;
    check("R3", bit_of(which), exp);
    tick();
    rd = 1'b0;
    check("R3", bit_of(which), 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    int k, h, seen;
    repeat (3) tick();
    // R6 reset state
    check("R6", res[3], 1'b0);
    check("R6", res[0], 1'b0);
    rst_n = 1'b1;
    repeat (2) tick();

    // R4 and R5: sweep of clock-pin config, level and accumulator bit
    for (int v = 0; v < 8; v++) begin
      ckgp = v[2]; ckpin = v[1]; acc0 = v[0];
      #1;
      check("R4", res[2], v[2] ? v[1] : 1'b1);
      check("R5", res[1], v[0]);
    end

    // R1 R2 R3 R8 width sweep over pins, widths and strobe periods
    for (int p = 1; p <= 4; p++)
      for (int w = 1; w <= 7; w++)
        for (int which = 0; which < 2; which++)
          trial(which, w, p);

    // R8 two short low periods whose strobes together would reach two
    per = 2;
    repeat (3) tick();
    pin_a = 1'b0; repeat (2) tick();
    pin_a = 1'b1; repeat (2) tick();
    pin_a = 1'b0; repeat (2) tick();
    pin_a = 1'b1; repeat (5) tick();
    check("R8", res[3], 1'b0);

    // R7 read lands on the qualifying edge
    per = 4;
    repeat (3) tick();
    pin_b = 1'b0;
    k = ncyc + 1;
    seen = 0; h = 0;
    for (int e = k + 3; seen < 2; e++) if (e % 4 == 0) begin seen++; h = e; end
    while (ncyc != h - 1) tick();
    rd = 1'b1;
    tick();
    rd = 1'b0;
    check("R7", res[0], 1'b1);
    repeat (6) tick();
    pin_b = 1'b1;
    repeat (4) tick();
    rd = 1'b1; tick(); rd = 1'b0;
    check("R7", res[0], 1'b0);

    // R6 reset clears a set latch
    per = 1;
    pin_a = 1'b0; repeat (6) tick(); pin_a = 1'b1; repeat (4) tick();
    check("R1", res[3], 1'b1);
    rst_n = 1'b0;
    tick();
    check("R6", res[3], 1'b0);
    rst_n = 1'b1;
    repeat (2) tick();
    check("R6", res[3], 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule